// File: doc/BRIEF.md
# Multiplexed Bus Machine-Cycle Sequencer

This block is a bus master that carries out one single-byte machine cycle at a time on a bus where the low address byte and the data byte share the same lines. The core side issues a request with a cycle kind, a 16-bit address and a write byte. The kind is one of opcode fetch, memory read, memory write, port read or port write. The block then steps through its T-states, one per clock. During the first state it pulses an address-latch strobe. In the middle of the cycle it lowers a read or write strobe. Status and space-select lines stay valid for the whole cycle. When the cycle ends, the block returns the captured byte together with a one-clock completion pulse.

A slow target holds the ready input low to stretch the cycle. The strobe phase then lasts as long as the target needs. Opcode fetches take their address from an internal program counter, which the block advances itself. A fetch carries one extra T-state after the byte is captured, so that the core has time to decode it. A port access puts its 8-bit port number on both the shared low lines and the upper address lines.

Top module: `mbus_cycle_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `rd_n` and `wr_n` are 1, `ale` is 0, `ad_oe` is 0, `rsp_done` is 0 and `pc_val` is 0. Whenever `req_ready` is 1, the strobes are high, `ale` is low and `ad_oe` is low.
- R2: A request (`req_valid` = 1) is taken only on a clock edge where `req_ready` is 1. A request presented while a cycle is running has no effect on that cycle, and does not start a new cycle afterwards.
- R3: In the first T-state after acceptance (T1), `ale` = 1 and `ad_oe` = 1. `ad_out` carries address bits 7:0 and `a_hi` carries address bits 15:8. `ale` is 1 for exactly that one clock.
- R4: For port cycles (kind 3 = port read, kind 4 = port write), the port number is bits 7:0 of `req_addr`. In T1 that number appears on both `ad_out` and `a_hi`.
- R5: Kind codes and their `{io_m, st1, st0}` values: 0 opcode fetch = 011; 1 memory read = 010; 2 memory write = 001; 3 port read = 110; 4 port write = 101. These values hold from T1 until the cycle ends.
- R6: In T2, `ale` = 0. Read kinds (0, 1, 3) drive `rd_n` low with `ad_oe` = 0. Write kinds (2, 4) drive `wr_n` low with `ad_oe` = 1 and the write byte on `ad_out`.
- R7: `rdy_in` low in T2 inserts wait states after T2. Each wait state holds the strobe, `ad_out` and `a_hi`. T3 follows the first clock in which `rdy_in` is seen high.
- R8: Read kinds capture `ad_in` at the end of T3, and the strobe is still low in T3. The captured byte is on `rsp_data` while `rsp_done` is 1.
- R9: A cycle with no waits lasts 3 T-states for kinds 1 to 4 and 4 T-states for an opcode fetch. In T4 both strobes are high and `ad_oe` is 0. `rsp_done` is 1 for exactly the one clock after the last T-state, and `req_ready` is 1 in that clock.
- R10: An opcode fetch ignores `req_addr` and places `pc_val` on the address lines. `pc_val` increases by 1 at the end of T2, so the new value is visible from the next clock on.
- R11: `rd_n` and `wr_n` are never low together. On a write, the byte on `ad_out` stays unchanged from T2 until `wr_n` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per period |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Core requests a machine cycle |
| req_kind | input | 3 | Cycle kind code (see R5) |
| req_addr | input | 16 | Memory address, or port number in bits 7:0 |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| rsp_data | output | 8 | Byte captured by a read cycle |
| rsp_done | output | 1 | One-clock completion pulse |
| pc_val | output | 16 | Internal program counter |
| a_hi | output | 8 | Upper address lines |
| ad_out | output | 8 | Shared low address/data lines, outgoing value |
| ad_oe | output | 1 | Output enable for the shared lines |
| ad_in | input | 8 | Shared low lines, incoming value |
| ale | output | 1 | Address-latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| io_m | output | 1 | 1 = port space, 0 = memory space |
| st1 | output | 1 | Status bit 1 |
| st0 | output | 1 | Status bit 0 |
| rdy_in | input | 1 | Target ready; low adds wait states |

## Verification
A wrong phase register shows up on the bus within one clock. `ale` stays up longer than one clock, a strobe falls during T1 or T4, or the strobe rises before the target has signalled ready. In every case the completion pulse then lands on a different clock from the one counted from acceptance. A stale captured byte or a wrong program counter first shows up at the end of the cycle: on `rsp_data` during the completion pulse, or on the address lines in T1 of the next fetch. Because of this, each cycle is checked phase by phase and also end to end.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [2:0] {
        CK_FETCH = 3'd0,
        CK_MRD   = 3'd1,
        CK_MWR   = 3'd2,
        CK_IORD  = 3'd3,
        CK_IOWR  = 3'd4
    } cyc_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_TW   = 3'd3,
        PH_T3   = 3'd4,
        PH_T4   = 3'd5
    } phase_e;

endpackage

// File: rtl/mbus_status_enc.sv
module mbus_status_enc
    import mbus_pkg::*;
(
    input  cyc_kind_e kind,
    output logic      io_m,
    output logic      s1,
    output logic      s0,
    output logic      is_read,
    output logic      is_write,
    output logic      is_fetch
);

    always_comb begin
        io_m     = 1'b0;
        s1       = 1'b1;
        s0       = 1'b0;
        is_read  = 1'b1;
        is_write = 1'b0;
        is_fetch = 1'b0;
        case (kind)
            CK_FETCH: begin
                s0       = 1'b1;
                is_fetch = 1'b1;
            end
            CK_MWR: begin
                s1       = 1'b0;
                s0       = 1'b1;
                is_read  = 1'b0;
                is_write = 1'b1;
            end
            CK_IORD: begin
                io_m = 1'b1;
            end
            CK_IOWR: begin
                io_m     = 1'b1;
                s1       = 1'b0;
                s0       = 1'b1;
                is_read  = 1'b0;
                is_write = 1'b1;
            end
            default: begin
                // memory read; unused codes fall here as well
            end
        endcase
    end

endmodule

// File: rtl/mbus_pin_drive.sv
module mbus_pin_drive
    import mbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  phase_e          phase,
    input  logic            is_read,
    input  logic            is_write,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic [AW-DW-1:0] a_hi,
    output logic [DW-1:0]   ad_out,
    output logic            ad_oe,
    output logic            ale,
    output logic            rd_n,
    output logic            wr_n
);

    localparam int HW = AW - DW;

    logic in_t1;
    logic in_strobe;
    logic active;

    always_comb begin
        in_t1     = (phase == PH_T1);
        in_strobe = (phase == PH_T2) || (phase == PH_TW) || (phase == PH_T3);
        active    = (phase != PH_IDLE);

        ale    = in_t1;
        rd_n   = !(in_strobe && is_read);
        wr_n   = !(in_strobe && is_write);
        ad_oe  = in_t1 || (in_strobe && is_write);
        a_hi   = active ? addr[AW-1:DW] : {HW{1'b0}};

        if (in_t1) begin
            ad_out = addr[DW-1:0];
        end else if (in_strobe && is_write) begin
            ad_out = wdata;
        end else begin
            ad_out = {DW{1'b0}};
        end
    end

endmodule

// File: rtl/mbus_cycle_seq.sv
module mbus_cycle_seq
    import mbus_pkg::*;
#(
    parameter int          AW     = 16,
    parameter int          DW     = 8,
    parameter logic [15:0] PC_RST = 16'h0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_kind,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             req_ready,
    output logic [DW-1:0]    rsp_data,
    output logic             rsp_done,
    output logic [AW-1:0]    pc_val,
    output logic [AW-DW-1:0] a_hi,
    output logic [DW-1:0]    ad_out,
    output logic             ad_oe,
    input  logic [DW-1:0]    ad_in,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic             io_m,
    output logic             st1,
    output logic             st0,
    input  logic             rdy_in
);

    localparam int HW = AW - DW;

    typedef struct packed {
        phase_e        ph;
        cyc_kind_e     kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [AW-1:0] pc;
        logic [DW-1:0] rdata;
        logic          done;
    } seq_t;

    seq_t st_d, st_q;

    logic      k_read, k_write, k_fetch;
    phase_e    cur_ph;
    cyc_kind_e in_kind;
    logic      in_fetch, in_port;
    logic [HW-1:0] port_mirror;

    assign in_kind  = cyc_kind_e'(req_kind);
    assign in_fetch = (in_kind == CK_FETCH);
    assign in_port  = (in_kind == CK_IORD) || (in_kind == CK_IOWR);
    assign cur_ph   = st_q.ph;

    // port number repeated across the upper lines
    for (genvar i = 0; i < HW; i++) begin : g_mirror
        assign port_mirror[i] = req_addr[i % DW];
    end

    mbus_status_enc u_enc (
        .kind     (st_q.kind),
        .io_m     (io_m),
        .s1       (st1),
        .s0       (st0),
        .is_read  (k_read),
        .is_write (k_write),
        .is_fetch (k_fetch)
    );

    mbus_pin_drive #(.AW(AW), .DW(DW)) u_pins (
        .phase    (st_q.ph),
        .is_read  (k_read),
        .is_write (k_write),
        .addr     (st_q.addr),
        .wdata    (st_q.wdata),
        .a_hi     (a_hi),
        .ad_out   (ad_out),
        .ad_oe    (ad_oe),
        .ale      (ale),
        .rd_n     (rd_n),
        .wr_n     (wr_n)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.ph    = PH_T1;
                    st_d.kind  = in_kind;
                    st_d.wdata = req_wdata;
                    if (in_fetch) begin
                        st_d.addr = st_q.pc;
                    end else if (in_port) begin
                        st_d.addr = {port_mirror, req_addr[DW-1:0]};
                    end else begin
                        st_d.addr = req_addr;
                    end
                end
            end
            PH_T1: begin
                st_d.ph = PH_T2;
            end
            PH_T2: begin
                if (k_fetch) begin
                    st_d.pc = st_q.pc + 1'b1;
                end
                st_d.ph = rdy_in ? PH_T3 : PH_TW;
            end
            PH_TW: begin
                st_d.ph = rdy_in ? PH_T3 : PH_TW;
            end
            PH_T3: begin
                if (k_read) begin
                    st_d.rdata = ad_in;
                end
                if (k_fetch) begin
                    st_d.ph = PH_T4;
                end else begin
                    st_d.ph   = PH_IDLE;
                    st_d.done = 1'b1;
                end
            end
            PH_T4: begin
                st_d.ph   = PH_IDLE;
                st_d.done = 1'b1;
            end
            default: begin
                st_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph    <= PH_IDLE;
            st_q.kind  <= CK_MRD;
            st_q.addr  <= '0;
            st_q.wdata <= '0;
            st_q.pc    <= AW'(PC_RST);
            st_q.rdata <= '0;
            st_q.done  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = (st_q.ph == PH_IDLE);
    assign rsp_data  = st_q.rdata;
    assign rsp_done  = st_q.done;
    assign pc_val    = st_q.pc;

endmodule

// File: rtl/mbus_cycle_seq_chk.sv
module mbus_cycle_seq_chk
    import mbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input phase_e           phase,
    input logic             is_fetch,
    input logic             req_ready,
    input logic             rsp_done,
    input logic [AW-1:0]    pc_val,
    input logic [AW-DW-1:0] a_hi,
    input logic [DW-1:0]    ad_out,
    input logic             ad_oe,
    input logic             ale,
    input logic             rd_n,
    input logic             wr_n,
    input logic             io_m,
    input logic             rdy_in
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (rd_n && wr_n && !ale && !ad_oe));

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> wr_n);

    // R3
    ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (!ale && (!rd_n || !wr_n)));

    // R4
    io_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && io_m) |-> (a_hi == ad_out));

    // R7
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_T2 || phase == PH_TW) && !rdy_in) |=>
        (phase == PH_TW && $stable(rd_n) && $stable(wr_n) && $stable(ad_out) && $stable(a_hi)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R10
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T2 && is_fetch) |=> (pc_val == $past(pc_val) + 1'b1));

endmodule

bind mbus_cycle_seq mbus_cycle_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (cur_ph),
    .is_fetch  (k_fetch),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .pc_val    (pc_val),
    .a_hi      (a_hi),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .io_m      (io_m),
    .rdy_in    (rdy_in)
);

// File: tb/mbus_cycle_seq_tb.sv
module mbus_cycle_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic        req_ready;
    logic [7:0]  rsp_data;
    logic        rsp_done;
    logic [15:0] pc_val;
    logic [7:0]  a_hi;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  ad_in = 8'h0;
    logic        ale;
    logic        rd_n;
    logic        wr_n;
    logic        io_m;
    logic        st1;
    logic        st0;
    logic        rdy_in = 1'b1;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;
    logic [15:0] pc_exp = 16'h0;

    always #2 clk = ~clk;

    mbus_cycle_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_data(rsp_data), .rsp_done(rsp_done), .pc_val(pc_val), .a_hi(a_hi),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale), .rd_n(rd_n),
        .wr_n(wr_n), .io_m(io_m), .st1(st1), .st0(st0), .rdy_in(rdy_in)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] stat_exp(input logic [2:0] k);
        case (k)
            3'd0: return 3'b011;
            3'd2: return 3'b001;
            3'd3: return 3'b110;
            3'd4: return 3'b101;
            default: return 3'b010;
        endcase
    endfunction

    // one machine cycle, checked phase by phase
    task automatic run_cycle(input logic [2:0] kind, input logic [15:0] addr,
                             input logic [7:0] wd, input int nwait,
                             input logic [7:0] dev, input bit poke);
        bit is_wr = (kind == 3'd2) || (kind == 3'd4);
        bit is_port = (kind == 3'd3) || (kind == 3'd4);
        bit is_fetch = (kind == 3'd0);
        logic [15:0] ea;
        logic [2:0] se = stat_exp(kind);
        int cyc = 0;
        ea = is_fetch ? pc_exp : (is_port ? {addr[7:0], addr[7:0]} : addr);
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 idle before request", req_ready, 1);
        req_valid = 1'b1; req_kind = kind; req_addr = addr; req_wdata = wd;
        @(negedge clk); cyc++;
        req_valid = 1'b0;
        // T1
        chk(ale == 1'b1 && ad_oe == 1'b1, "R3 T1 ale/oe", {ale, ad_oe}, 2'b11);
        chk(ad_out == ea[7:0], is_port ? "R4 port on low lines" : "R3 low address", ad_out, ea[7:0]);
        chk(a_hi == ea[15:8], is_port ? "R4 port mirrored high" : (is_fetch ? "R10 fetch uses pc" : "R3 high address"), a_hi, ea[15:8]);
        chk({io_m, st1, st0} == se, "R5 status in T1", {io_m, st1, st0}, se);
        chk(rd_n && wr_n, "R11 no strobe in T1", {rd_n, wr_n}, 2'b11);
        rdy_in = (nwait == 0);
        ad_in = dev;
        @(negedge clk); cyc++;
        // T2
        chk(ale == 1'b0, "R6 ale low in T2", ale, 0);
        chk({rd_n, wr_n} == (is_wr ? 2'b10 : 2'b01), "R6 strobe in T2", {rd_n, wr_n}, is_wr ? 2'b10 : 2'b01);
        chk(ad_oe == is_wr, "R6 oe in T2", ad_oe, is_wr);
        if (is_wr) chk(ad_out == wd, "R6 write data in T2", ad_out, wd);
        if (poke) begin
            req_valid = 1'b1; req_kind = 3'd2; req_addr = 16'h5555;
        end
        for (int w = 0; w < nwait; w++) begin
            @(negedge clk); cyc++;
            chk({rd_n, wr_n} == (is_wr ? 2'b10 : 2'b01), "R7 strobe held in wait", {rd_n, wr_n}, is_wr ? 2'b10 : 2'b01);
            if (is_wr) chk(ad_out == wd, "R11 write data held", ad_out, wd);
            if (w == nwait - 1) rdy_in = 1'b1;
        end
        @(negedge clk); cyc++;
        // T3
        chk({rd_n, wr_n} == (is_wr ? 2'b10 : 2'b01), "R8 strobe low in T3", {rd_n, wr_n}, is_wr ? 2'b10 : 2'b01);
        if (is_wr) chk(ad_out == wd, "R11 write data in T3", ad_out, wd);
        chk({io_m, st1, st0} == se, "R5 status in T3", {io_m, st1, st0}, se);
        if (is_fetch) chk(pc_val == pc_exp + 16'd1, "R10 pc advanced after T2", pc_val, pc_exp + 16'd1);
        req_valid = 1'b0;
        if (is_fetch) begin
            @(negedge clk); cyc++;
            chk(rd_n && wr_n && !ad_oe, "R9 T4 quiet bus", {rd_n, wr_n, ad_oe}, 3'b110);
            pc_exp = pc_exp + 16'd1;
        end
        @(negedge clk);
        chk(rsp_done == 1'b1 && req_ready == 1'b1, "R9 done after last T-state", {rsp_done, req_ready}, 2'b11);
        chk(cyc == (is_fetch ? 4 : 3) + nwait, "R9 T-state count", cyc, (is_fetch ? 4 : 3) + nwait);
        if (!is_wr) chk(rsp_data == dev, "R8 captured byte", rsp_data, dev);
        @(negedge clk);
        chk(rsp_done == 1'b0, "R9 done one clock", rsp_done, 0);
        chk(ale == 1'b0 && req_ready == 1'b1, poke ? "R2 busy request ignored" : "R1 idle after cycle", {ale, req_ready}, 2'b01);
        chk(rd_n && wr_n && !ad_oe, "R1 idle bus quiet", {rd_n, wr_n, ad_oe}, 3'b110);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready && rd_n && wr_n && !ale && !ad_oe && !rsp_done, "R1 reset outputs",
            {req_ready, rd_n, wr_n, ale, ad_oe, rsp_done}, 6'b111000);
        chk(pc_val == 16'h0, "R1 reset pc", pc_val, 0);
        rst_n = 1'b1;
        run_cycle(3'd1, 16'h12A5, 8'h00, 0, 8'h3C, 0);
        run_cycle(3'd2, 16'hBEEF, 8'h5A, 2, 8'h00, 0);
        run_cycle(3'd3, 16'hFF47, 8'h00, 1, 8'h99, 0);
        run_cycle(3'd4, 16'h0081, 8'hC3, 0, 8'h00, 0);
        run_cycle(3'd0, 16'hDEAD, 8'h00, 0, 8'h76, 0);
        run_cycle(3'd0, 16'h4321, 8'h00, 3, 8'hE1, 0);
        run_cycle(3'd0, 16'h0000, 8'h00, 0, 8'h0F, 0);
        run_cycle(3'd1, 16'h8001, 8'h00, 1, 8'hA5, 1);
        run_cycle(3'd4, 16'h12FE, 8'h3E, 2, 8'h00, 1);
        run_cycle(3'd0, 16'hFFFF, 8'h00, 1, 8'h55, 1);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++;
            nfail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule